// File: doc/BRIEF.md
# Serial Nonvolatile Memory Command Sequencer

This block is an SPI master for a small serial nonvolatile memory with a 13-bit byte address. A host asks for one of four single-byte operations through a start/done handshake: read a byte, write a byte, read the status byte, or write the status byte. The block turns each request into one or more chip-select frames. It builds every command byte, packs the upper address bits into the opcode byte, and wraps writes in write-enable and write-disable frames on its own. It returns read data and status on a host-side output.

Serial clock is derived from the system clock by a parameterised half-period divider. Data goes out on the rising edge after setup while the clock is low, and comes back on the falling edge. The write-protect line is raised for the whole of any modifying operation. The hold line stays inactive. After the frames that start an internal write cycle in the memory, the block waits a parameterised settle interval before it goes on.

Top module: `spi_nvm_seq`

## Requirements
- R1: After reset and whenever idle, `cs_n` is high, `sck` is low, `busy` and `done` are low, `wp_n` is low and `hold_n` is high.
- R2: Within a frame, each bit is placed on `mosi` while `sck` is low. `sck` then goes high for `HALF_DIV` cycles and returns low. `mosi` never changes while `sck` is high, `sck` pulses only while `cs_n` is low, and bits leave most significant first.
- R3: Operation code 0 (byte read) is one frame of 24 clocks. MOSI carries `{addr[12:8],3'b011}`, then `addr[7:0]`, then eight ones. The last eight MISO bits, sampled while `sck` is high and taken MSB first, appear on `rdata` when `done` pulses.
- R4: Operation code 1 (byte write) is three frames: 8 clocks of 0x06, then 24 clocks of `{addr[12:8],3'b010}`, `addr[7:0]`, `wdata`, then 8 clocks of 0x04. `rdata` keeps its previous value.
- R5: Operation code 2 (status read) is one frame of 16 clocks: 0x05 followed by eight ones. The eight bits returned are presented on `rdata`. The status layout is bit 7 protect-enable, bits 3:2 block-protect, and bit 1 write-enable latch.
- R6: Operation code 3 (status write) is two frames: 8 clocks of 0x06, then 16 clocks of 0x01 followed by `wdata`.
- R7: `wp_n` is high from the cycle after a write or status-write request is accepted until `done`, and low at all other times. `hold_n` is always high.
- R8: At least `SETTLE_CYCLES` cycles pass between the end of the last frame of a byte write and `done`. The same minimum applies between the two frames of a status write, and between the end of a status write's last frame and `done`.
- R9: `cs_n` stays high for at least `2*HALF_DIV` cycles between any two frames.
- R10: `busy` rises the cycle after `start` is accepted and falls in the cycle where `done` pulses high for exactly one cycle. A `start` while `busy` is high is ignored and produces no frame and no extra `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request pulse, taken only when not busy |
| op | input | 2 | Operation: 0 read, 1 write, 2 status read, 3 status write |
| addr | input | 13 | Byte address for read and write |
| wdata | input | 8 | Byte to write, or new status value |
| rdata | output | 8 | Last byte or status read back |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the memory |
| miso | input | 1 | Serial data from the memory |
| cs_n | output | 1 | Chip select, active low |
| wp_n | output | 1 | Write-protect line, high releases protection |
| hold_n | output | 1 | Hold line, held inactive high |

## Verification
The bench goes after the packing of address bits 12..8 in front of the 3-bit tail at both address extremes (0 and 0x1FFF). A design that shifted or truncated them would address the wrong location, and the following readback would return the wrong byte. It records every frame's exact bit count and MOSI stream, so a missing enable or disable wrapper, a wrong opcode tail or a misplaced MOSI park level shows up as a frame mismatch. It measures the settle interval and the inter-frame chip-select gap in cycles, which catches a sequencer that skips a wait. It also fires a second request in the middle of a write, which catches a block that accepts it, adds frames or emits a second `done`.

// File: rtl/spi_nvm_pkg.sv
package spi_nvm_pkg;

    localparam int ADDR_W  = 13;
    localparam int WORD_W  = 24;
    localparam int NBITS_W = 5;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_RDSTAT = 2'd2,
        OP_WRSTAT = 2'd3
    } nvm_op_e;

    localparam logic [7:0] CMD_WEN   = 8'h06;
    localparam logic [7:0] CMD_WDIS  = 8'h04;
    localparam logic [7:0] CMD_SRD   = 8'h05;
    localparam logic [7:0] CMD_SWR   = 8'h01;
    localparam logic [2:0] TAIL_RD   = 3'b011;
    localparam logic [2:0] TAIL_WR   = 3'b010;
    localparam logic [15:0] PARK_ONES = 16'hFFFF;

    // One chip-select frame: left-aligned bit stream, number of clocks,
    // whether a settle wait follows it, and whether it ends the operation.
    typedef struct packed {
        logic [WORD_W-1:0]  word;
        logic [NBITS_W-1:0] nbits;
        logic               settle;
        logic               last;
    } frame_desc_t;

    function automatic logic op_modifies(nvm_op_e o);
        return (o == OP_WRITE) || (o == OP_WRSTAT);
    endfunction

    function automatic logic op_returns(nvm_op_e o);
        return (o == OP_READ) || (o == OP_RDSTAT);
    endfunction

    function automatic frame_desc_t step_desc(nvm_op_e o, logic [1:0] step,
                                              logic [ADDR_W-1:0] a, logic [7:0] wd);
        frame_desc_t d;
        d = '0;
        unique case (o)
            OP_READ: begin
                d.word  = {a[12:8], TAIL_RD, a[7:0], 8'hFF};
                d.nbits = 5'd24;
                d.last  = 1'b1;
            end
            OP_WRITE: begin
                case (step)
                    2'd0: begin
                        d.word  = {CMD_WEN, PARK_ONES};
                        d.nbits = 5'd8;
                    end
                    2'd1: begin
                        d.word  = {a[12:8], TAIL_WR, a[7:0], wd};
                        d.nbits = 5'd24;
                    end
                    default: begin
                        d.word   = {CMD_WDIS, PARK_ONES};
                        d.nbits  = 5'd8;
                        d.settle = 1'b1;
                        d.last   = 1'b1;
                    end
                endcase
            end
            OP_RDSTAT: begin
                d.word  = {CMD_SRD, PARK_ONES};
                d.nbits = 5'd16;
                d.last  = 1'b1;
            end
            default: begin
                if (step == 2'd0) begin
                    d.word   = {CMD_WEN, PARK_ONES};
                    d.nbits  = 5'd8;
                    d.settle = 1'b1;
                end else begin
                    d.word   = {CMD_SWR, wd, 8'hFF};
                    d.nbits  = 5'd16;
                    d.settle = 1'b1;
                    d.last   = 1'b1;
                end
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/spi_nvm_frame.sv
module spi_nvm_frame
    import spi_nvm_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  logic [WORD_W-1:0]  word,
    input  logic [NBITS_W-1:0] nbits,
    input  logic               miso,
    output logic               sck,
    output logic               cs_n,
    output logic               mosi,
    output logic [7:0]         rx_byte,
    output logic               fdone
);
    localparam int GAP_CYC = 2 * HALF_DIV;
    localparam int CW      = $clog2(GAP_CYC + 1);
    localparam logic [CW-1:0] HALF_LD = CW'(HALF_DIV - 1);
    localparam logic [CW-1:0] GAP_LD  = CW'(GAP_CYC - 1);

    typedef enum logic [2:0] {F_IDLE, F_LOW, F_HIGH, F_TAIL, F_GAP} fstate_e;

    fstate_e            state;
    logic [CW-1:0]      cnt;
    logic [WORD_W-1:0]  shreg;
    logic [NBITS_W-1:0] left;
    logic               cnt_zero;

    assign cnt_zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= F_IDLE;
            cnt     <= '0;
            shreg   <= '1;
            left    <= '0;
            rx_byte <= '0;
            fdone   <= 1'b0;
        end else begin
            fdone <= 1'b0;
            unique case (state)
                F_IDLE: begin
                    if (go) begin
                        shreg <= word;
                        left  <= nbits;
                        cnt   <= HALF_LD;
                        state <= F_LOW;
                    end
                end
                F_LOW: begin
                    if (cnt_zero) begin
                        cnt   <= HALF_LD;
                        state <= F_HIGH;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                F_HIGH: begin
                    if (cnt_zero) begin
                        rx_byte <= {rx_byte[6:0], miso};
                        shreg   <= {shreg[WORD_W-2:0], 1'b1};
                        left    <= left - 1'b1;
                        cnt     <= HALF_LD;
                        state   <= (left == NBITS_W'(1)) ? F_TAIL : F_LOW;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                F_TAIL: begin
                    if (cnt_zero) begin
                        cnt   <= GAP_LD;
                        state <= F_GAP;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (cnt_zero) begin
                        fdone <= 1'b1;
                        state <= F_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    assign sck  = (state == F_HIGH);
    assign cs_n = !((state == F_LOW) || (state == F_HIGH) || (state == F_TAIL));
    assign mosi = shreg[WORD_W-1];

endmodule

// File: rtl/spi_nvm_timer.sv
module spi_nvm_timer #(
    parameter int SETTLE_CYCLES = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    output logic expired
);
    localparam int TW = $clog2(SETTLE_CYCLES + 1);

    logic [TW-1:0] cnt;
    logic          run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            run     <= 1'b0;
            expired <= 1'b0;
        end else begin
            expired <= 1'b0;
            if (kick) begin
                cnt <= TW'(SETTLE_CYCLES);
                run <= 1'b1;
            end else if (run) begin
                if (cnt <= TW'(1)) begin
                    run     <= 1'b0;
                    expired <= 1'b1;
                end
                cnt <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_nvm_ctrl.sv
module spi_nvm_ctrl
    import spi_nvm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  nvm_op_e            op,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [7:0]         wdata,
    input  logic               fdone,
    input  logic [7:0]         rx_byte,
    input  logic               tmr_expired,
    output logic               go,
    output logic [WORD_W-1:0]  word,
    output logic [NBITS_W-1:0] nbits,
    output logic               tmr_kick,
    output logic               busy,
    output logic               done,
    output logic [7:0]         rdata,
    output logic               wp_n
);
    typedef enum logic [1:0] {C_IDLE, C_ISSUE, C_WAIT, C_SETTLE} cstate_e;

    cstate_e           state;
    nvm_op_e           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        wd_q;
    logic [1:0]        step;
    frame_desc_t       desc;
    logic              frame_end;
    logic              step_over;

    assign desc      = step_desc(op_q, step, addr_q, wd_q);
    assign frame_end = (state == C_WAIT) && fdone;
    assign step_over = (frame_end && !desc.settle) ||
                       ((state == C_SETTLE) && tmr_expired);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= C_IDLE;
            op_q   <= OP_READ;
            addr_q <= '0;
            wd_q   <= '0;
            step   <= '0;
            rdata  <= '0;
            done   <= 1'b0;
            wp_n   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                C_IDLE: begin
                    if (start) begin
                        op_q   <= op;
                        addr_q <= addr;
                        wd_q   <= wdata;
                        step   <= '0;
                        wp_n   <= op_modifies(op);
                        state  <= C_ISSUE;
                    end
                end
                C_ISSUE: state <= C_WAIT;
                C_WAIT: begin
                    if (fdone) begin
                        if (desc.last && op_returns(op_q)) begin
                            rdata <= rx_byte;
                        end
                        if (desc.settle) begin
                            state <= C_SETTLE;
                        end
                    end
                end
                default: ;
            endcase
            if (step_over) begin
                if (desc.last) begin
                    state <= C_IDLE;
                    done  <= 1'b1;
                    wp_n  <= 1'b0;
                end else begin
                    step  <= step + 1'b1;
                    state <= C_ISSUE;
                end
            end
        end
    end

    assign go       = (state == C_ISSUE);
    assign word     = desc.word;
    assign nbits    = desc.nbits;
    assign tmr_kick = frame_end && desc.settle;
    assign busy     = (state != C_IDLE);

endmodule

// File: rtl/spi_nvm_seq.sv
module spi_nvm_seq
    import spi_nvm_pkg::*;
#(
    parameter int HALF_DIV      = 4,
    parameter int SETTLE_CYCLES = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [1:0]  op,
    input  logic [12:0] addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        busy,
    output logic        done,
    output logic        sck,
    output logic        mosi,
    input  logic        miso,
    output logic        cs_n,
    output logic        wp_n,
    output logic        hold_n
);
    logic               go;
    logic [WORD_W-1:0]  word;
    logic [NBITS_W-1:0] nbits;
    logic [7:0]         rx_byte;
    logic               fdone;
    logic               tmr_kick;
    logic               tmr_expired;

    spi_nvm_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .op          (nvm_op_e'(op)),
        .addr        (addr),
        .wdata       (wdata),
        .fdone       (fdone),
        .rx_byte     (rx_byte),
        .tmr_expired (tmr_expired),
        .go          (go),
        .word        (word),
        .nbits       (nbits),
        .tmr_kick    (tmr_kick),
        .busy        (busy),
        .done        (done),
        .rdata       (rdata),
        .wp_n        (wp_n)
    );

    spi_nvm_frame #(.HALF_DIV(HALF_DIV)) u_frame (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .word    (word),
        .nbits   (nbits),
        .miso    (miso),
        .sck     (sck),
        .cs_n    (cs_n),
        .mosi    (mosi),
        .rx_byte (rx_byte),
        .fdone   (fdone)
    );

    spi_nvm_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .kick    (tmr_kick),
        .expired (tmr_expired)
    );

    assign hold_n = 1'b1;

endmodule

// File: rtl/spi_nvm_seq_chk.sv
module spi_nvm_seq_chk #(
    parameter int HALF_DIV = 4
) (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic done,
    input logic sck,
    input logic mosi,
    input logic cs_n,
    input logic wp_n,
    input logic hold_n
);
    localparam int GAP_CYC = 2 * HALF_DIV;
    localparam int GW      = $clog2(GAP_CYC + 1);

    logic [GW-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap <= GW'(GAP_CYC);
        end else if (!cs_n) begin
            gap <= '0;
        end else if (gap != GW'(GAP_CYC)) begin
            gap <= gap + 1'b1;
        end
    end

    // R2
    sck_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        sck |-> !cs_n);

    // R2
    mosi_steady_high_chk: assert property (@(posedge clk) disable iff (rst)
        sck |-> $stable(mosi));

    // R1
    idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cs_n && !sck));

    // R7
    wp_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !wp_n);

    // R7
    hold_inactive_chk: assert property (@(posedge clk) disable iff (rst)
        hold_n);

    // R10
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> (gap == GW'(GAP_CYC)));

endmodule

bind spi_nvm_seq spi_nvm_seq_chk #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .busy   (busy),
    .done   (done),
    .sck    (sck),
    .mosi   (mosi),
    .cs_n   (cs_n),
    .wp_n   (wp_n),
    .hold_n (hold_n)
);

// File: tb/spi_nvm_seq_tb.sv
module spi_nvm_seq_tb;
    localparam int HALF   = 2;
    localparam int SETTLE = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [12:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        busy, done, sck, mosi, cs_n, wp_n, hold_n;
    logic        miso = 1'b0;

    always #5 clk = ~clk;

    spi_nvm_seq #(.HALF_DIV(HALF), .SETTLE_CYCLES(SETTLE)) u_dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .addr(addr),
        .wdata(wdata), .rdata(rdata), .busy(busy), .done(done),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n),
        .wp_n(wp_n), .hold_n(hold_n)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ndone = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (done) ndone <= ndone + 1;
    end

    // ---------------- behavioural memory model ----------------
    logic [7:0]  mem [8192];
    logic [7:0]  stat = 8'h00;
    logic        wel = 1'b0;
    logic [31:0] sh;
    int          bcnt;
    logic [7:0]  cmd;
    logic [12:0] acur;
    logic [7:0]  sv;
    logic [31:0] fr_bits [16];
    int          fr_len [16];
    logic        fr_wp [16];
    int          fr_fall [16];
    int          fr_rise [16];
    int          nfr = 0;

    initial begin
        for (int i = 0; i < 8192; i++) mem[i] = 8'hA5;
    end

    always @(negedge cs_n) begin
        sh = '0;
        bcnt = 0;
        if (nfr < 16) begin
            fr_wp[nfr] = wp_n;
            fr_fall[nfr] = cyc;
        end
    end

    always @(posedge sck) begin
        if (!cs_n) begin
            sh = {sh[30:0], mosi};
            bcnt++;
            if (bcnt == 8) cmd = sh[7:0];
            if (bcnt == 16) acur = {cmd[7:3], sh[7:0]};
        end
    end

    always @(negedge sck) begin
        if (!cs_n) begin
            if (bcnt >= 16 && bcnt < 24 && cmd[2:0] == 3'b011)
                miso = mem[acur][23-bcnt];
            else if (bcnt >= 8 && bcnt < 16 && cmd == 8'h05) begin
                sv = {stat[7:2], wel, 1'b0};
                miso = sv[15-bcnt];
            end
        end
    end

    always @(posedge cs_n) begin
        if (nfr < 16) begin
            fr_bits[nfr] = sh;
            fr_len[nfr] = bcnt;
            fr_rise[nfr] = cyc;
            nfr++;
        end
        if (bcnt == 8 && cmd == 8'h06) wel = 1'b1;
        if (bcnt == 8 && cmd == 8'h04) wel = 1'b0;
        if (bcnt == 24 && cmd[2:0] == 3'b010 && wel) mem[{cmd[7:3], sh[15:8]}] = sh[7:0];
        if (bcnt == 16 && cmd == 8'h01 && wel) begin
            stat = sh[7:0] & 8'h8C;
            wel = 1'b0;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_frame(input int idx, input logic [31:0] bits, input int len,
                             input logic wpv, input string tag);
        check(fr_len[idx] == len, {tag, " frame length"}, fr_len[idx], len);
        check(fr_bits[idx] == bits, {tag, " frame bits"}, fr_bits[idx], bits);
        check(fr_wp[idx] == wpv, {tag, " wp level"}, fr_wp[idx], wpv);
    endtask

    int done_cyc;
    logic [7:0] got;

    task automatic issue(input logic [1:0] o, input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        op = o; addr = a; wdata = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        done_cyc = cyc;
        got = rdata;
        check(!busy, "R10 busy low with done", busy, 0);
        @(negedge clk);
        check(!done, "R10 done one cycle", done, 0);
    endtask

    task automatic run_op(input logic [1:0] o, input logic [12:0] a, input logic [7:0] d);
        nfr = 0;
        issue(o, a, d);
        check(busy, "R10 busy after start", busy, 1);
        wait_done();
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check(cs_n && !sck && !busy && !done && !wp_n && hold_n, "R1 reset state",
              {cs_n, sck, busy, done, wp_n, hold_n}, 6'b100001);
    endtask

    task automatic t_write_read(input logic [12:0] a, input logic [7:0] d);
        logic [7:0] prev;
        int nd;
        prev = rdata;
        nd = ndone;
        run_op(2'd1, a, d);
        check(nfr == 3, "R4 write frame count", nfr, 3);
        chk_frame(0, 32'h06, 8, 1'b1, "R4 R7 enable");
        chk_frame(1, {8'h0, a[12:8], 3'b010, a[7:0], d}, 24, 1'b1, "R4 data");
        chk_frame(2, 32'h04, 8, 1'b1, "R4 R7 disable");
        check(rdata == prev, "R4 rdata held", rdata, prev);
        check(done_cyc - fr_rise[2] >= SETTLE, "R8 write settle", done_cyc - fr_rise[2], SETTLE);
        check(fr_fall[1] - fr_rise[0] >= 2*HALF, "R9 gap", fr_fall[1] - fr_rise[0], 2*HALF);
        check(ndone - nd == 1, "R10 one done", ndone - nd, 1);
        run_op(2'd0, a, 8'h00);
        check(nfr == 1, "R3 read frame count", nfr, 1);
        chk_frame(0, {8'h0, a[12:8], 3'b011, a[7:0], 8'hFF}, 24, 1'b0, "R3 R7 read");
        check(got == d, "R3 readback", got, d);
        check(!wp_n && hold_n, "R7 idle lines", {wp_n, hold_n}, 2'b01);
    endtask

    task automatic t_status(input logic [7:0] v, input logic [7:0] expv);
        run_op(2'd3, 13'h0, v);
        check(nfr == 2, "R6 frame count", nfr, 2);
        chk_frame(0, 32'h06, 8, 1'b1, "R6 enable");
        chk_frame(1, {16'h0, 8'h01, v}, 16, 1'b1, "R6 status write");
        check(fr_fall[1] - fr_rise[0] >= SETTLE, "R8 status enable settle",
              fr_fall[1] - fr_rise[0], SETTLE);
        check(done_cyc - fr_rise[1] >= SETTLE, "R8 status write settle",
              done_cyc - fr_rise[1], SETTLE);
        run_op(2'd2, 13'h0, 8'h00);
        chk_frame(0, 32'h05FF, 16, 1'b0, "R5 status read");
        check(got == expv, "R5 status value", got, expv);
    endtask

    task automatic t_ignore_busy();
        int nd;
        nd = ndone;
        nfr = 0;
        issue(2'd1, 13'h0555, 8'h3C);
        repeat (40) @(negedge clk);
        op = 2'd0; addr = 13'h1ABC; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (60) @(negedge clk);
        check(nfr == 3, "R10 no extra frames", nfr, 3);
        check(ndone - nd == 1, "R10 single done", ndone - nd, 1);
        check(!busy && cs_n, "R10 idle after ignore", {busy, cs_n}, 2'b01);
        chk_frame(1, {8'h0, 5'h05, 3'b010, 8'h55, 8'h3C}, 24, 1'b1, "R10 kept request");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        run_op(2'd2, 13'h0, 8'h00);
        chk_frame(0, 32'h05FF, 16, 1'b0, "R5 initial status");
        check(got == 8'h00, "R5 initial status value", got, 8'h00);
        t_write_read(13'h1ABC, 8'h5A);
        t_write_read(13'h0000, 8'hFF);
        t_write_read(13'h1FFF, 8'h00);
        t_write_read(13'h0E31, 8'h96);
        t_status(8'h8C, 8'h8C);
        t_status(8'h04, 8'h04);
        t_ignore_busy();
        run_op(2'd0, 13'h0555, 8'h00);
        check(got == 8'h3C, "R3 readback after ignored start", got, 8'h3C);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule